// File: doc/BRIEF.md
# Write-Port Reservation Issue Interlock

This block sits in the issue stage of a pipeline whose functional units have different latencies and share one register-file write port. An integer or load path finishes after 1 cycle, a pipelined floating-point adder after 4, a pipelined multiplier after 7 and a divider that is not pipelined after a configurable number of cycles. Because only one result can be written per cycle, port contention is treated as a structural hazard and resolved before an instruction leaves issue. Every hazard check and every stall is decided in the issue stage. No later stage stalls.

The block keeps a reservation shift register. Each slot marks a future cycle in which an already-issued instruction will write back, and each slot also holds that instruction's destination register. The register shifts by one slot every clock. In each cycle the waiting candidate is checked against the slot at its own latency offset, which catches a port conflict. It is also checked against every slot that writes back later than it would, which catches a write-after-write clash on the same destination. A divide is also refused while an earlier divide is still in flight. If any check fails, the candidate is stalled for one cycle and checked again in the next cycle. If no check fails, it issues in the same cycle and its write-back slot is reserved.

Top module: `wb_port_interlock`

## Requirements
- R1: Reset clears every reservation and destination tag and the divider-busy state. After reset, the first valid candidate of any class issues with no stall.
- R2: `issue` is high exactly when `cand_valid` is high, reset is low and no conflict exists. `stall` is high exactly when `cand_valid` is high, reset is low and a conflict exists. Both are low when `cand_valid` is low.
- R3: The unit class code sets the write-back latency: 0 is integer/load with latency 1, 1 is add with latency 4, 2 is multiply with latency 7, and 3 is divide with latency DIV_LAT (default 24). An instruction issued in cycle t writes back in cycle t+latency.
- R4: A candidate whose write-back cycle equals the write-back cycle of an already-issued instruction is stalled.
- R5: Reservations age by one cycle per clock, so a stalled candidate is checked again in the next cycle. Example: after a multiply issues in cycle t, an add stalls in cycle t+3 and issues in cycle t+4.
- R6: A candidate is stalled when an in-flight instruction with the same destination register writes back strictly later than the candidate would.
- R7: An in-flight instruction that writes back later than the candidate but has a different destination register does not stall the candidate.
- R8: A divide candidate is stalled while an earlier divide is in flight. A divide issued in cycle t blocks divides in cycles t+1 to t+DIV_LAT-1, and a divide is accepted in cycle t+DIV_LAT.
- R9: A stalled candidate reserves no slot. A later candidate that targets the write-back cycle the stalled one would have used issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | An instruction is waiting to issue |
| cand_unit | input | 2 | Unit class code of the candidate (0 integer/load, 1 add, 2 multiply, 3 divide) |
| cand_dest | input | REG_W | Destination register of the candidate |
| issue | output | 1 | Candidate issues in this cycle |
| stall | output | 1 | Candidate is held in issue for this cycle |

## Verification
The hardest cases to reach are a write-after-write clash and a port collision at the divider's far end. In both, an instruction that is already in flight and a younger candidate must land on particular relative slots a specific number of cycles apart. Directed sequences build these cases exactly: a multiply followed one cycle later by an add to the same destination, or to a different one, and a divide followed by divides at the edge of its busy window. Long random runs then take over. They draw destinations from a range of four so that tags collide often, and they hold a stalled candidate until it issues. This drives repeated re-checks against a bench model that tracks reservations by absolute cycle number.

// File: rtl/wb_resv_pkg.sv
package wb_resv_pkg;

    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_ADD = 2'd1,
        UC_MUL = 2'd2,
        UC_DIV = 2'd3
    } unit_e;

    localparam int unsigned LAT_INT = 1;
    localparam int unsigned LAT_ADD = 4;
    localparam int unsigned LAT_MUL = 7;

    typedef struct packed {
        logic port;
        logic waw;
        logic div;
    } conflict_t;

    function automatic int unsigned unit_lat(unit_e u, int unsigned div_lat);
        case (u)
            UC_INT:  return LAT_INT;
            UC_ADD:  return LAT_ADD;
            UC_MUL:  return LAT_MUL;
            default: return div_lat;
        endcase
    endfunction

endpackage

// File: rtl/wb_resv_shift.sv
module wb_resv_shift #(
    parameter int unsigned DEPTH = 24,
    parameter int unsigned REG_W = 5,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ins_en,
    input  logic [IDX_W-1:0]            ins_idx,
    input  logic [REG_W-1:0]            ins_tag,
    output logic [DEPTH-1:0]            slot_v,
    output logic [DEPTH-1:0][REG_W-1:0] slot_tag
);
    // Slot j, seen in cycle t, means a write-back in cycle t+j+1.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v   <= '0;
            slot_tag <= '0;
        end else begin
            for (int j = 0; j < int'(DEPTH); j++) begin
                if (ins_en && int'(ins_idx) == j) begin
                    slot_v[j]   <= 1'b1;
                    slot_tag[j] <= ins_tag;
                end else if (j < int'(DEPTH) - 1) begin
                    slot_v[j]   <= slot_v[j+1];
                    slot_tag[j] <= slot_tag[j+1];
                end else begin
                    slot_v[j]   <= 1'b0;
                    slot_tag[j] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/wb_resv_hazard.sv
module wb_resv_hazard
    import wb_resv_pkg::*;
#(
    parameter int unsigned DEPTH = 24,
    parameter int unsigned REG_W = 5,
    localparam int unsigned LAT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]            slot_v,
    input  logic [DEPTH-1:0][REG_W-1:0] slot_tag,
    input  logic [LAT_W-1:0]            cand_lat,
    input  logic [REG_W-1:0]            cand_dest,
    input  logic                        cand_is_div,
    input  logic                        div_busy,
    output conflict_t                   hit
);
    always_comb begin
        hit = '0;
        for (int j = 0; j < int'(DEPTH); j++) begin
            if (slot_v[j] && j == int'(cand_lat) - 1)
                hit.port = 1'b1;
            if (slot_v[j] && j >= int'(cand_lat) && slot_tag[j] == cand_dest)
                hit.waw = 1'b1;
        end
        hit.div = cand_is_div && div_busy;
    end
endmodule

// File: rtl/wb_resv_div.sv
module wb_resv_div #(
    parameter int unsigned DIV_LAT = 24,
    localparam int unsigned CNT_W = $clog2(DIV_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic div_start,
    output logic div_busy
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (div_start)
            remain <= CNT_W'(DIV_LAT - 1);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign div_busy = (remain != '0);
endmodule

// File: rtl/wb_port_interlock.sv
module wb_port_interlock
    import wb_resv_pkg::*;
#(
    parameter int unsigned REG_W   = 5,
    parameter int unsigned DIV_LAT = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_valid,
    input  logic [1:0]       cand_unit,
    input  logic [REG_W-1:0] cand_dest,
    output logic             issue,
    output logic             stall
);
    localparam int unsigned DEPTH = (DIV_LAT > LAT_MUL) ? DIV_LAT : LAT_MUL + 1;
    localparam int unsigned LAT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    unit_e                       unit;
    logic [LAT_W-1:0]            lat;
    logic [DEPTH-1:0]            slot_v;
    logic [DEPTH-1:0][REG_W-1:0] slot_tag;
    logic                        div_busy;
    conflict_t                   hit;
    logic                        any_hit;
    logic                        ins_en;
    logic [IDX_W-1:0]            ins_idx;

    assign unit    = unit_e'(cand_unit);
    assign lat     = LAT_W'(unit_lat(unit, DIV_LAT));
    assign any_hit = hit.port | hit.waw | hit.div;
    assign issue   = cand_valid & ~rst & ~any_hit;
    assign stall   = cand_valid & ~rst & any_hit;

    // A latency-1 result lands in the very next cycle and never needs a slot.
    assign ins_en  = issue && (lat >= LAT_W'(2));
    assign ins_idx = IDX_W'(lat - LAT_W'(2));

    wb_resv_shift #(.DEPTH(DEPTH), .REG_W(REG_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ins_en   (ins_en),
        .ins_idx  (ins_idx),
        .ins_tag  (cand_dest),
        .slot_v   (slot_v),
        .slot_tag (slot_tag)
    );

    wb_resv_hazard #(.DEPTH(DEPTH), .REG_W(REG_W)) u_hazard (
        .slot_v      (slot_v),
        .slot_tag    (slot_tag),
        .cand_lat    (lat),
        .cand_dest   (cand_dest),
        .cand_is_div (unit == UC_DIV),
        .div_busy    (div_busy),
        .hit         (hit)
    );

    wb_resv_div #(.DIV_LAT(DIV_LAT)) u_div (
        .clk       (clk),
        .rst       (rst),
        .div_start (issue && unit == UC_DIV),
        .div_busy  (div_busy)
    );
endmodule

// File: rtl/wb_port_interlock_chk.sv
module wb_port_interlock_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cand_valid,
    input logic [1:0]       cand_unit,
    input logic [REG_W-1:0] cand_dest,
    input logic             issue,
    input logic             stall
);
    p_outputs_excl_r2: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (issue ^ stall));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !cand_valid |-> (!issue && !stall));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cand_valid) |-> issue);

    // Multiply at t writes t+7; add at t+3 also targets t+7.
    p_port_conflict_r4: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_unit == 2'd1 && $past(issue && cand_unit == 2'd2, 3)) |-> stall);

    // Multiply at t writes t+7; add at t+1 to the same register writes t+5.
    p_waw_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_unit == 2'd1 && $past(issue && cand_unit == 2'd2)
         && $past(cand_dest) == cand_dest) |-> stall);

    p_div_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_unit == 2'd3 && $past(issue && cand_unit == 2'd3)) |-> stall);
endmodule

bind wb_port_interlock wb_port_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_wb_port_interlock.sv
`timescale 1ns/1ps
module test_wb_port_interlock;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned DIV_LAT = 24;
    localparam int unsigned RING    = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cand_valid = 1'b0;
    logic [1:0]       cand_unit = 2'd0;
    logic [REG_W-1:0] cand_dest = '0;
    logic             issue;
    logic             stall;

    int errors = 0;
    int checks = 0;

    // Bench model: reservations indexed by absolute cycle modulo RING.
    logic             m_v   [RING];
    logic [REG_W-1:0] m_tag [RING];
    int               m_cyc = 0;
    int               m_div_until = 0;

    always #2.5 clk = ~clk;

    wb_port_interlock #(.REG_W(REG_W), .DIV_LAT(DIV_LAT)) i_wb_port_interlock (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_unit(cand_unit),
        .cand_dest(cand_dest), .issue(issue), .stall(stall)
    );

    function automatic int lat_of(input logic [1:0] u);
        case (u)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 7;
            default: return DIV_LAT;
        endcase
    endfunction

    function automatic logic model_conflict(input logic [1:0] u, input logic [REG_W-1:0] d);
        int l = lat_of(u);
        logic c = m_v[(m_cyc + l) % RING];
        for (int k = l + 1; k <= int'(DIV_LAT); k++)
            if (m_v[(m_cyc + k) % RING] && m_tag[(m_cyc + k) % RING] == d) c = 1'b1;
        if (u == 2'd3 && m_cyc < m_div_until) c = 1'b1;
        return c;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < int'(RING); i++) begin
            m_v[i] = 1'b0;
            m_tag[i] = '0;
        end
        m_cyc = 0;
        m_div_until = 0;
    endtask

    logic last_stall = 1'b0;

    task automatic step(input logic v, input logic [1:0] u, input logic [REG_W-1:0] d,
                        input string req);
        logic c, e_iss, e_stl;
        @(negedge clk);
        cand_valid = v;
        cand_unit  = u;
        cand_dest  = d;
        #1;
        c     = model_conflict(u, d);
        e_iss = v && !c;
        e_stl = v && c;
        checks++;
        if (issue !== e_iss || stall !== e_stl) begin
            errors++;
            $display("FAIL %s cycle %0d: issue/stall=%b%b expected %b%b (unit %0d dest %0d)",
                     req, m_cyc, issue, stall, e_iss, e_stl, u, d);
        end
        last_stall = e_stl;
        @(posedge clk);
        if (e_iss) begin
            m_v[(m_cyc + lat_of(u)) % RING]   = 1'b1;
            m_tag[(m_cyc + lat_of(u)) % RING] = d;
            if (u == 2'd3) m_div_until = m_cyc + DIV_LAT;
        end
        m_v[m_cyc % RING] = 1'b0;
        m_cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, "R2 idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cand_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0]       ru;
        logic [REG_W-1:0] rd;
        logic             rv;
        model_clear();
        do_reset();

        // R1: after reset a divide issues immediately.
        step(1'b1, 2'd3, 5'd1, "R1 reset clear");
        // R8: divide in flight blocks divides until t+DIV_LAT.
        step(1'b1, 2'd3, 5'd2, "R8 div busy");
        idle(DIV_LAT - 3);
        step(1'b1, 2'd3, 5'd2, "R8 div busy edge");
        step(1'b1, 2'd3, 5'd2, "R8 div accepted");
        idle(DIV_LAT + 2);

        // R4 and R5: multiply at t, add at t+3 collides, add at t+4 issues.
        step(1'b1, 2'd2, 5'd3, "R3 mul issue");
        idle(2);
        step(1'b1, 2'd1, 5'd4, "R4 port conflict");
        step(1'b1, 2'd1, 5'd4, "R5 recheck issue");
        idle(8);

        // R6: same destination, younger add would finish first.
        step(1'b1, 2'd2, 5'd5, "R3 mul issue");
        step(1'b1, 2'd1, 5'd5, "R6 waw stall");
        idle(2);
        // R9: the stalled add's slot (t+5) is free for an integer op now.
        step(1'b1, 2'd0, 5'd9, "R9 stalled leaves no slot");
        idle(8);

        // R7: different destination, no stall.
        step(1'b1, 2'd2, 5'd5, "R3 mul issue");
        step(1'b1, 2'd1, 5'd6, "R7 no waw different dest");
        idle(8);

        // R3: integer back-to-back never conflicts with itself.
        step(1'b1, 2'd0, 5'd1, "R3 int issue");
        step(1'b1, 2'd0, 5'd1, "R3 int back to back");
        idle(2);

        // R1: reset in the middle clears a pending reservation.
        step(1'b1, 2'd2, 5'd7, "R3 mul issue");
        do_reset();
        idle(2);
        step(1'b1, 2'd0, 5'd7, "R1 reset clears slots");

        // Random mix, stalled candidates held until they issue.
        void'($urandom(32'd12345));
        for (int n = 0; n < 4000; n++) begin
            if (!last_stall) begin
                rv = ($urandom % 4) != 0;
                ru = 2'($urandom % 4);
                if (ru == 2'd3 && ($urandom % 3) != 0) ru = 2'd1;
                rd = REG_W'($urandom % 4);
            end
            step(rv, ru, rd, "R2 R4 R5 R6 R8 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule